// File: doc/BRIEF.md
# Parallel Nonvolatile Memory Page-Write Controller

This block sits behind an asynchronous, SRAM-style byte bus (active-low chip enable, output enable and write enable) and models the write path of an 8192 x 8 nonvolatile memory. The bus pins are brought into the system clock domain through a two-stage synchronizer. A write strobe is the synchronized falling edge of the combined chip-enable/write-enable low condition. Each strobe captures one address/data pair into a 64-byte page register.

A page load closes when no accepted strobe arrives for `LOAD_WIN` clock cycles. A self-timed commit of `TWC_CYC` cycles then starts. During it the buffered bytes are copied into the array one offset per cycle, and the bus is free. Any read issued while the commit runs is a status poll. It does not return array data. A single `write_allow` input decides at commit start whether the array is updated. A blocked commit still occupies the full timer.

Reads and writes go through the same pins: a system bus master loads a page, polls until the poll word matches the data written, then carries on.

Top module: `nvm_page_ctrl`

## Requirements
- R1: The address is 13 bits wide and selects one of 8192 bytes. While ce_n and oe_n are low and we_n is high, rdata_oe is high and rdata carries the addressed byte three clock edges after the pins settle. Otherwise rdata_oe is low and rdata is zero.
- R2: A write strobe is counted on the synchronized falling edge of (ce_n OR we_n). The address and data present then are loaded into the page register at offset addr[5:0]. The first strobe after idle fixes the page as addr[12:6].
- R3: A page load ends once LOAD_WIN clock cycles pass without an accepted strobe. The commit then writes every loaded offset (1 to 64 bytes) to the array at {page, offset}. Offsets not loaded keep their old contents.
- R4: A strobe during a page load whose addr[12:6] differs from the page fixed by the first strobe loads nothing and sets page_err to 1. page_err returns to 0 when the next page load starts.
- R5: For TWC_CYC cycles after a page load ends, a read returns a poll word. Bit 7 of the poll word is the complement of bit 7 of the last byte loaded, and bits 6 to 0 are zero. After the commit, reads return array data.
- R6: Strobes that arrive while a commit is running are ignored. They start no page load and change no array byte.
- R7: If write_allow is low when the page load ends, the commit timer still runs for TWC_CYC cycles and polls still return the poll word, but the array is left unchanged.
- R8: After reset, rdata_oe is 0, rdata is 0, page_err is 0, and the controller is idle.
- R9: When one offset is loaded more than once within a page, the value of the last strobe is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| write_allow | input | 1 | 1 lets a page commit update the array, 0 blocks it |
| rdata | output | 8 | Read data or poll word |
| rdata_oe | output | 1 | High while rdata is being driven for a read |
| page_err | output | 1 | Set by a strobe that falls outside the current page |

## Verification
A wrong sequencer state shows up at the ports within one read. If a commit is missed or never ends, the poll word stays where array data is expected, or array data appears where the poll word should be. A wrong page tag or offset shows up as a byte read back from the wrong address once the commit has ended, about LOAD_WIN plus TWC_CYC cycles after the last strobe. A protection or ignore path that leaks through changes a byte the bench wrote earlier, and the next read-back after the commit exposes it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int NVM_AW    = 13;
    localparam int NVM_DW    = 8;
    localparam int NVM_OFS_W = 6;
    localparam int NVM_PG_W  = NVM_AW - NVM_OFS_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COMMIT
    } seq_state_e;

    typedef struct packed {
        logic [NVM_AW-1:0] addr;
        logic [NVM_DW-1:0] data;
    } bus_word_t;

    typedef struct packed {
        logic      wr_fall;
        logic      rd_sel;
        bus_word_t word;
    } bus_evt_t;

    function automatic logic [NVM_PG_W-1:0] page_of(input logic [NVM_AW-1:0] a);
        return a[NVM_AW-1:NVM_OFS_W];
    endfunction

    function automatic logic [NVM_OFS_W-1:0] ofs_of(input logic [NVM_AW-1:0] a);
        return a[NVM_OFS_W-1:0];
    endfunction

    function automatic logic [NVM_DW-1:0] poll_word(input logic [NVM_DW-1:0] last);
        return {~last[NVM_DW-1], {(NVM_DW-1){1'b0}}};
    endfunction

endpackage

// File: rtl/nvm_bus_sync.sv
module nvm_bus_sync
    import nvm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [NVM_AW-1:0] addr,
    input  logic [NVM_DW-1:0] wdata,
    output bus_evt_t          evt
);

    typedef struct packed {
        logic      wstb_n;
        logic      rd;
        bus_word_t word;
    } stage_t;

    localparam stage_t STAGE_RST = '{wstb_n: 1'b1, rd: 1'b0, word: '0};

    stage_t s1, s2;
    logic   wstb_n_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1          <= STAGE_RST;
            s2          <= STAGE_RST;
            wstb_n_prev <= 1'b1;
        end else begin
            s1.wstb_n   <= ce_n | we_n;
            s1.rd       <= ~ce_n & ~oe_n & we_n;
            s1.word     <= '{addr: addr, data: wdata};
            s2          <= s1;
            wstb_n_prev <= s2.wstb_n;
        end
    end

    always_comb begin
        evt.wr_fall = wstb_n_prev & ~s2.wstb_n;
        evt.rd_sel  = s2.rd;
        evt.word    = s2.word;
    end

endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf
    import nvm_pkg::*;
#(
    parameter int PAGE_BYTES = 1 << NVM_OFS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [NVM_OFS_W-1:0] load_ofs,
    input  logic [NVM_DW-1:0]    load_data,
    input  logic                 clear,
    input  logic [NVM_OFS_W-1:0] rd_ofs,
    output logic [NVM_DW-1:0]    rd_byte,
    output logic                 rd_vld,
    output logic [NVM_DW-1:0]    last_data
);

    logic [NVM_DW-1:0]     bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            last_data <= '0;
        end else if (clear) begin
            vld_q <= '0;
        end else if (load_en) begin
            vld_q[load_ofs] <= 1'b1;
            last_data       <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en) bytes_q[load_ofs] <= load_data;
    end

    assign rd_byte = bytes_q[rd_ofs];
    assign rd_vld  = vld_q[rd_ofs];

    // R2: an accepted strobe marks its offset as holding data
    p_load_marks_r2: assert property (@(posedge clk) disable iff (rst)
        (load_en && !clear) |=> vld_q[$past(load_ofs)]);

    // R3: the buffer is empty once a commit has been closed out
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (rst)
        clear |=> (vld_q == '0));

endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
    import nvm_pkg::*;
#(
    parameter int LOAD_WIN   = 16,
    parameter int TWC_CYC    = 200,
    parameter int PAGE_BYTES = 1 << NVM_OFS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic [NVM_AW-1:0]    strobe_addr,
    input  logic                 write_allow,
    input  logic                 buf_vld,
    output logic                 load_en,
    output logic                 buf_clear,
    output logic                 busy,
    output logic                 page_err,
    output logic [NVM_OFS_W-1:0] commit_ofs,
    output logic [NVM_AW-1:0]    arr_waddr,
    output logic                 arr_we,
    output logic                 allow_q
);

    localparam int WIN_W = $clog2(LOAD_WIN + 1);
    localparam int TMR_W = $clog2(TWC_CYC + 1);

    seq_state_e            state;
    logic [NVM_PG_W-1:0]   tag_q;
    logic [WIN_W-1:0]      win_q;
    logic [TMR_W-1:0]      tmr_q;
    logic                  same_page;
    logic                  in_copy;

    assign same_page = (page_of(strobe_addr) == tag_q);
    assign in_copy   = (state == ST_COMMIT) && (tmr_q < TMR_W'(PAGE_BYTES));

    always_comb begin
        load_en = 1'b0;
        if (strobe) begin
            if (state == ST_IDLE)                    load_en = 1'b1;
            else if (state == ST_LOAD && same_page)  load_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tag_q    <= '0;
            win_q    <= '0;
            tmr_q    <= '0;
            page_err <= 1'b0;
            allow_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (strobe) begin
                        tag_q    <= page_of(strobe_addr);
                        win_q    <= '0;
                        page_err <= 1'b0;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (strobe && same_page) begin
                        win_q <= '0;
                    end else if (win_q == WIN_W'(LOAD_WIN - 1)) begin
                        if (strobe) page_err <= 1'b1;
                        tmr_q   <= '0;
                        allow_q <= write_allow;
                        state   <= ST_COMMIT;
                    end else begin
                        if (strobe) page_err <= 1'b1;
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_COMMIT: begin
                    if (tmr_q == TMR_W'(TWC_CYC - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_COMMIT);
    assign buf_clear  = (state == ST_COMMIT) && (tmr_q == TMR_W'(TWC_CYC - 1));
    assign commit_ofs = tmr_q[NVM_OFS_W-1:0];
    assign arr_waddr  = {tag_q, commit_ofs};
    assign arr_we     = in_copy && allow_q && buf_vld;

    // R4: a strobe outside the open page raises the error flag
    p_err_on_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && strobe && !same_page) |=> page_err);

    // R6: nothing is loaded while the commit timer runs
    p_no_load_in_commit_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load_en);

    // R3: the copy index never walks past the page
    p_copy_in_page_r3: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (tmr_q < TMR_W'(PAGE_BYTES)));

endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              allow_i,
    input  logic              we,
    input  logic [NVM_AW-1:0] waddr,
    input  logic [NVM_DW-1:0] wdata,
    input  logic [NVM_AW-1:0] raddr,
    output logic [NVM_DW-1:0] rdata
);

    localparam int DEPTH = 1 << NVM_AW;

    logic [NVM_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R7: the array changes only inside an allowed commit window
    p_we_in_commit_r7: assert property (@(posedge clk) disable iff (rst)
        we |-> (busy_i && allow_i));

endmodule

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl
    import nvm_pkg::*;
#(
    parameter int LOAD_WIN   = 16,
    parameter int TWC_CYC    = 200,
    parameter int PAGE_BYTES = 1 << NVM_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [NVM_AW-1:0] addr,
    input  logic [NVM_DW-1:0] wdata,
    input  logic              write_allow,
    output logic [NVM_DW-1:0] rdata,
    output logic              rdata_oe,
    output logic              page_err
);

    bus_evt_t             evt;
    logic                 load_en, buf_clear, busy, arr_we, allow_q, buf_vld;
    logic [NVM_OFS_W-1:0] commit_ofs;
    logic [NVM_AW-1:0]    arr_waddr;
    logic [NVM_DW-1:0]    buf_byte, last_data, arr_rd;

    nvm_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .addr  (addr),
        .wdata (wdata),
        .evt   (evt)
    );

    nvm_write_seq #(
        .LOAD_WIN   (LOAD_WIN),
        .TWC_CYC    (TWC_CYC),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .strobe      (evt.wr_fall),
        .strobe_addr (evt.word.addr),
        .write_allow (write_allow),
        .buf_vld     (buf_vld),
        .load_en     (load_en),
        .buf_clear   (buf_clear),
        .busy        (busy),
        .page_err    (page_err),
        .commit_ofs  (commit_ofs),
        .arr_waddr   (arr_waddr),
        .arr_we      (arr_we),
        .allow_q     (allow_q)
    );

    nvm_page_buf #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_ofs  (ofs_of(evt.word.addr)),
        .load_data (evt.word.data),
        .clear     (buf_clear),
        .rd_ofs    (commit_ofs),
        .rd_byte   (buf_byte),
        .rd_vld    (buf_vld),
        .last_data (last_data)
    );

    nvm_array u_arr (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy),
        .allow_i (allow_q),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wdata   (buf_byte),
        .raddr   (evt.word.addr),
        .rdata   (arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata_oe <= evt.rd_sel;
            if (!evt.rd_sel) rdata <= '0;
            else if (busy)   rdata <= poll_word(last_data);
            else             rdata <= arr_rd;
        end
    end

    // R1: data is driven only for a read seen on the pins three edges earlier
    p_oe_follows_pins_r1: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (!$past(ce_n, 3) && !$past(oe_n, 3) && $past(we_n, 3)));

    // R1: an idle bus leaves rdata at zero
    p_idle_rdata_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0));

endmodule

// File: tb/sim_nvm_page_ctrl.sv
module sim_nvm_page_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LOAD_WIN   = 20;
    localparam int TWC_CYC    = 100;
    localparam int SETTLE     = LOAD_WIN + TWC_CYC + 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        write_allow = 1'b1;
    logic [7:0]  rdata;
    logic        rdata_oe, page_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_page_ctrl #(.LOAD_WIN(LOAD_WIN), .TWC_CYC(TWC_CYC)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .write_allow(write_allow),
        .rdata(rdata), .rdata_oe(rdata_oe), .page_err(page_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic get_byte(input logic [12:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        d = rdata; oe = rdata_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R8 rdata_oe after reset", {7'd0, rdata_oe}, 8'h00);
        check("R8 rdata after reset", rdata, 8'h00);
        check("R8 page_err after reset", {7'd0, page_err}, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d; logic oe;
        put_byte(13'h0123, 8'hA5);
        wait_cyc(SETTLE);
        get_byte(13'h0123, d, oe);
        check("R1 R3 single byte read back", d, 8'hA5);
        check("R1 rdata_oe during read", {7'd0, oe}, 8'h01);
        wait_cyc(4);
        check("R1 rdata_oe after read", {7'd0, rdata_oe}, 8'h00);
        check("R1 rdata zero when idle", rdata, 8'h00);
    endtask

    task automatic t_page();
        logic [7:0] d; logic oe;
        put_byte(13'h0140, 8'h10);
        put_byte(13'h0141, 8'h21);
        put_byte(13'h017F, 8'h3F);
        put_byte(13'h0141, 8'h99);
        wait_cyc(SETTLE);
        get_byte(13'h0140, d, oe);
        check("R2 R3 page offset 0", d, 8'h10);
        get_byte(13'h017F, d, oe);
        check("R2 R3 page offset 63", d, 8'h3F);
        get_byte(13'h0141, d, oe);
        check("R9 last load of offset wins", d, 8'h99);
    endtask

    task automatic t_poll();
        logic [7:0] d; logic oe;
        put_byte(13'h0200, 8'h3C);
        wait_cyc(LOAD_WIN + 5);
        get_byte(13'h0200, d, oe);
        check("R5 poll with bit7 clear", d, 8'h80);
        wait_cyc(SETTLE);
        get_byte(13'h0200, d, oe);
        check("R5 data after commit", d, 8'h3C);
        put_byte(13'h0201, 8'hC3);
        wait_cyc(LOAD_WIN + 5);
        get_byte(13'h0201, d, oe);
        check("R5 poll with bit7 set", d, 8'h00);
        wait_cyc(SETTLE);
        get_byte(13'h0201, d, oe);
        check("R5 data after second commit", d, 8'hC3);
    endtask

    task automatic t_mismatch();
        logic [7:0] d; logic oe;
        put_byte(13'h0480, 8'h77);
        wait_cyc(SETTLE);
        put_byte(13'h0400, 8'h11);
        put_byte(13'h0480, 8'h22);
        check("R4 page_err after foreign strobe", {7'd0, page_err}, 8'h01);
        wait_cyc(SETTLE);
        get_byte(13'h0400, d, oe);
        check("R4 in-page byte committed", d, 8'h11);
        get_byte(13'h0480, d, oe);
        check("R4 foreign byte ignored", d, 8'h77);
        put_byte(13'h0500, 8'h05);
        check("R4 page_err cleared on new page", {7'd0, page_err}, 8'h00);
        wait_cyc(SETTLE);
    endtask

    task automatic t_protect();
        logic [7:0] d; logic oe;
        write_allow = 1'b0;
        put_byte(13'h0123, 8'h5A);
        wait_cyc(LOAD_WIN + 5);
        get_byte(13'h0123, d, oe);
        check("R7 poll runs while blocked", d, 8'h80);
        wait_cyc(SETTLE);
        write_allow = 1'b1;
        get_byte(13'h0123, d, oe);
        check("R7 array unchanged when blocked", d, 8'hA5);
    endtask

    task automatic t_commit_ignore();
        logic [7:0] d; logic oe;
        put_byte(13'h0600, 8'h42);
        wait_cyc(LOAD_WIN + 5);
        put_byte(13'h0123, 8'h99);
        wait_cyc(SETTLE);
        get_byte(13'h0123, d, oe);
        check("R6 strobe during commit ignored", d, 8'hA5);
        get_byte(13'h0600, d, oe);
        check("R6 commit in flight completes", d, 8'h42);
    endtask

    task automatic t_full_page();
        logic [7:0] d; logic oe;
        for (int i = 0; i < 64; i++) put_byte(13'h1FC0 + 13'(i), 8'(i) ^ 8'h5A);
        wait_cyc(SETTLE);
        for (int i = 0; i < 64; i++) begin
            get_byte(13'h1FC0 + 13'(i), d, oe);
            check("R3 full 64-byte top page", d, 8'(i) ^ 8'h5A);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_single();
        t_page();
        t_poll();
        t_mismatch();
        t_protect();
        t_commit_ignore();
        t_full_page();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule